// File: doc/BRIEF.md
# Two-Wire Bus Addressed Slave Engine

This block is the slave side of a two-wire open-drain serial bus with one clock line and one data line. It watches both lines through synchronisers, recognises START, repeated START and STOP conditions, and takes in an address byte. If the address matches the configured one, it acknowledges. It then either accepts write bytes from the bus master or supplies read bytes to it. Every byte is acknowledged by whichever side received it.

The block never drives a line high. It only asserts a pull-low enable for each line, and the pad or board resistor supplies the high level.

On the local side, received bytes are offered through a valid/ready output channel. Bytes to transmit are taken from a valid/ready input channel. Between bytes the engine holds the clock line low for as long as the local side is not ready, so the master waits. Any START resets the frame logic to address reception, wherever in a byte it appears. A STOP abandons whatever transfer is in progress.

Top module: `twowire_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `scl_pull_o`, `sda_pull_o`, `rx_valid_o` and `tx_ready_o` are all 0.
- R2: After a START, the engine shifts in 8 bits on rising clock edges, most significant bit first. Bits 7..1 form the address and bit 0 is the direction (0 = write, 1 = read). When bits 7..1 equal `dev_addr_i`, the engine pulls SDA low for the whole ninth clock pulse as the acknowledge.
- R3: When the address does not match, neither pull-low output is asserted until the next START or STOP. No byte is delivered on the receive channel.
- R4: In a write, each following 8-bit byte (MSB first) is presented on `rx_data_o` with `rx_valid_o`. It is held stable until `rx_ready_i`, and it is acknowledged by pulling SDA low during its ninth clock. Bytes arrive in bus order.
- R5: When a write byte completes while the previous byte is still unaccepted, SCL is held low until the local side accepts it. Only then does the new byte become visible and get acknowledged, and no byte is lost.
- R6: In a read, after the address acknowledge, the engine sends the byte taken from `tx_data_i` MSB first. It changes SDA only while SCL is low.
- R7: Before each read byte, SCL is held low until `tx_valid_i` is high. The byte is taken in the cycle where both `tx_valid_i` and `tx_ready_o` are 1.
- R8: A not-acknowledge from the master (SDA high in the ninth clock of a read byte) ends the read. The engine takes no further byte and pulls neither line until the next START or STOP.
- R9: A START or repeated START at any point, including in the middle of a byte, discards the partial byte and restarts address reception.
- R10: A STOP at any point, including in the middle of a byte, returns the engine to idle without acknowledging and without delivering the partial byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretching) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| dev_addr_i | input | BYTE_W-1 | Address this slave answers to |
| rx_data_o | output | BYTE_W | Byte received in a write |
| rx_valid_o | output | 1 | `rx_data_o` holds an unaccepted byte |
| rx_ready_i | input | 1 | Local side accepts the received byte |
| tx_data_i | input | BYTE_W | Byte to send in a read |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| tx_ready_o | output | 1 | Engine is waiting for a read byte |

## Verification
The local side draining the receive holding register and the bus side trying to push the next completed write byte into it can happen in the same cycle. This is provoked by holding `rx_ready_i` low across two write bytes and releasing it while SCL is being stretched. The release makes the pop and the pending push meet, and the run is judged by the stretch seen by the bus master, by both bytes arriving in order, and by the acknowledge that follows. The second collision is between a START or STOP and the middle of a byte, which must override the bit counter; it is judged by the next frame's acknowledge and delivered data.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WWAIT,
    ST_WACK,
    ST_RWAIT,
    ST_RD,
    ST_RACK,
    ST_IGNORE
  } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic prev_o
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '1;
      prev_o <= 1'b1;
    end else begin
      pipe   <= {pipe[STAGES-2:0], d_i};
      prev_o <= pipe[STAGES-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/tws_cond_det.sv
module tws_cond_det (
  input  logic scl_now,
  input  logic scl_was,
  input  logic sda_now,
  input  logic sda_was,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  assign scl_rise_o = scl_now & ~scl_was;
  assign scl_fall_o = ~scl_now & scl_was;
  assign start_o    = scl_now & scl_was & sda_was & ~sda_now;
  assign stop_o     = scl_now & scl_was & ~sda_was & sda_now;

endmodule

// File: rtl/twowire_slave.sv
module twowire_slave
  import tws_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic [BYTE_W-2:0] dev_addr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);

  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [ADDR_W-1:0] dev);
    return frame[BYTE_W-1:1] == dev;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur,
                                                 input logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  // line synchronisers: index 0 = clock line, 1 = data line
  logic [1:0] raw_lines, syn_lines, prv_lines;
  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      tws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (raw_lines[g]),
        .q_o    (syn_lines[g]),
        .prev_o (prv_lines[g])
      );
    end
  endgenerate

  logic scl_s, sda_s;
  assign scl_s = syn_lines[0];
  assign sda_s = syn_lines[1];

  // bus events, brought out as named wires
  logic scl_rise, scl_fall, start_ev, stop_ev;

  tws_cond_det u_cond (
    .scl_now    (syn_lines[0]),
    .scl_was    (prv_lines[0]),
    .sda_now    (syn_lines[1]),
    .sda_was    (prv_lines[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  tws_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_full;
  logic [BYTE_W-1:0] shreg;
  logic              rw_q;
  logic              mack_q;
  logic              sda_pull_q, scl_pull_q;
  logic [BYTE_W-1:0] rx_data_q;
  logic              rx_valid_q;

  logic rx_pop, rx_push, tx_load, byte_done;
  assign rx_pop    = rx_valid_q & rx_ready_i;
  assign rx_push   = (state == ST_WWAIT) & ~rx_valid_q & ~start_ev & ~stop_ev;
  assign tx_load   = (state == ST_RWAIT) & tx_valid_i & ~start_ev & ~stop_ev;
  assign byte_done = scl_fall & byte_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      byte_full  <= 1'b0;
      shreg      <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b1;
      sda_pull_q <= 1'b0;
      scl_pull_q <= 1'b0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      if (rx_pop) rx_valid_q <= 1'b0;

      if (start_ev || stop_ev) begin
        state      <= start_ev ? ST_ADDR : ST_IDLE;
        bit_cnt    <= '0;
        byte_full  <= 1'b0;
        sda_pull_q <= 1'b0;
        scl_pull_q <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg   <= shift_in(shreg, sda_s);
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end else if (byte_done) begin
              byte_full <= 1'b0;
              bit_cnt   <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(shreg, dev_addr_i)) begin
                  state      <= ST_AACK;
                  sda_pull_q <= 1'b1;
                  rw_q       <= shreg[0];
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                state      <= ST_WWAIT;
                scl_pull_q <= 1'b1;
              end
            end
          end
          ST_WWAIT: begin
            if (rx_push) begin
              rx_data_q  <= shreg;
              rx_valid_q <= 1'b1;
              scl_pull_q <= 1'b0;
              sda_pull_q <= 1'b1;
              state      <= ST_WACK;
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_pull_q <= 1'b0;
              if (rw_q) begin
                state      <= ST_RWAIT;
                scl_pull_q <= 1'b1;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_pull_q <= 1'b0;
              state      <= ST_WR;
            end
          end
          ST_RWAIT: begin
            if (tx_load) begin
              shreg      <= tx_data_i;
              sda_pull_q <= ~tx_data_i[BYTE_W-1];
              scl_pull_q <= 1'b0;
              bit_cnt    <= '0;
              state      <= ST_RD;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                byte_full  <= 1'b0;
                sda_pull_q <= 1'b0;
                state      <= ST_RACK;
              end else begin
                shreg      <= shreg << 1;
                sda_pull_q <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= sda_s;
            end else if (scl_fall) begin
              if (!mack_q) begin
                state      <= ST_RWAIT;
                scl_pull_q <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_ready_o = (state == ST_RWAIT);

  // assertions

  assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR && bit_cnt == '0 && !sda_pull_o && !scl_pull_o));

  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_pull_o && !scl_pull_o));

  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sda_pull_o && !scl_pull_o));

  assert_rx_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  assert_sda_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  assert_stretch_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> $past(scl_fall));

endmodule

// File: tb/twowire_slave_bench.sv
module twowire_slave_bench;

  localparam int H = 16;
  localparam logic [6:0] DEV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl, sda;
  logic scl_pull_o, sda_pull_o;
  logic [7:0] rx_data_o, tx_data;
  logic rx_valid_o, rx_ready, tx_valid, tx_ready_o;

  assign scl = !(m_scl_low || scl_pull_o);
  assign sda = !(m_sda_low || sda_pull_o);

  twowire_slave u_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .dev_addr_i(DEV),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o)
  );

  int nvec = 0, nfail = 0, last_wait = 0;
  bit done = 0, rx_hold = 0, tx_hold = 0, tx_pend = 0;
  string quiet_req = "";
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model of the local side and bus quietness, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      rx_ready = !rx_hold;
      if (rx_valid_o && rx_ready) begin
        if (rxq.size() == 0) chk("R4 unexpected received byte", {24'h0, rx_data_o}, 32'hFFFF);
        else begin
          chk("R4 received byte", {24'h0, rx_data_o}, {24'h0, rxq[0]});
          rxq.delete(0);
        end
      end
      if (tx_pend && txq.size() > 0) txq.delete(0);
      tx_valid = !tx_hold && (txq.size() > 0);
      tx_data  = tx_valid ? txq[0] : 8'h00;
      tx_pend  = tx_valid && tx_ready_o;
      if (quiet_req != "") chk(quiet_req, {30'h0, scl_pull_o, sda_pull_o}, 0);
    end else begin
      rx_ready = 1'b0;
      tx_valid = 1'b0;
      tx_data  = 8'h00;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic clk_bit(input logic drive, output logic seen);
    m_sda_low = !drive;
    tick(H/2);
    m_scl_low = 1'b0;
    last_wait = 0;
    while (!scl) begin tick(1); last_wait++; end
    tick(H/2);
    @(negedge clk);
    seen = sda;
    tick(H/2);
    m_scl_low = 1'b1;
    tick(H/2);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    tick(H/2);
    m_scl_low = 1'b0;
    while (!scl) tick(1);
    tick(H);
    m_sda_low = 1'b1;
    tick(H);
    m_scl_low = 1'b1;
    tick(H/2);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    tick(H/2);
    m_scl_low = 1'b0;
    while (!scl) tick(1);
    tick(H);
    m_sda_low = 1'b0;
    tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v, output int w0);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      if (i == 7) w0 = last_wait;
      v[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  initial begin
    logic a, s;
    logic [7:0] v;
    int w;
    tick(5);
    chk("R1 scl pull in reset", {31'h0, scl_pull_o}, 0);
    chk("R1 sda pull in reset", {31'h0, sda_pull_o}, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 scl pull after reset", {31'h0, scl_pull_o}, 0);
    chk("R1 sda pull after reset", {31'h0, sda_pull_o}, 0);
    chk("R1 rx valid after reset", {31'h0, rx_valid_o}, 0);
    chk("R1 tx ready after reset", {31'h0, tx_ready_o}, 0);

    // R2 / R4: plain write of several patterns
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R2 write address ack", {31'h0, a}, 1);
    foreach (v_list[i]) begin
      rxq.push_back(v_list[i]);
      send_byte(v_list[i], a); chk("R4 write data ack", {31'h0, a}, 1);
    end
    m_stop();
    tick(40);
    chk("R4 write bytes delivered", rxq.size(), 0);

    // R5: receive holding register full, stretch until drained
    rx_hold = 1;
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R5 address ack", {31'h0, a}, 1);
    rxq.push_back(8'h5C); rxq.push_back(8'hE1);
    send_byte(8'h5C, a); chk("R5 first byte ack", {31'h0, a}, 1);
    fork begin tick(700); rx_hold = 0; end join_none
    send_byte(8'hE1, a);
    chk("R5 stretched before ack", {31'h0, (last_wait > 100)}, 1);
    chk("R5 second byte ack", {31'h0, a}, 1);
    m_stop();
    tick(40);
    chk("R5 both bytes delivered in order", rxq.size(), 0);

    // R6 / R8: read two bytes, NACK ends it
    txq.push_back(8'h96); txq.push_back(8'h0F); txq.push_back(8'hC3);
    m_start();
    send_byte({DEV, 1'b1}, a); chk("R2 read address ack", {31'h0, a}, 1);
    read_byte(1'b1, v, w); chk("R6 read byte 1", {24'h0, v}, 32'h96);
    read_byte(1'b0, v, w); chk("R6 read byte 2", {24'h0, v}, 32'h0F);
    quiet_req = "R8 released after nack";
    clk_bit(1'b1, s); chk("R8 no data after nack", {31'h0, s}, 1);
    tick(40);
    m_stop();
    quiet_req = "";
    chk("R8 no further byte taken", txq.size(), 1);
    txq.delete();
    tick(20);

    // R7: read with late transmit data
    tx_hold = 1;
    txq.push_back(8'h4E);
    m_start();
    send_byte({DEV, 1'b1}, a); chk("R7 address ack", {31'h0, a}, 1);
    fork begin tick(500); tx_hold = 0; end join_none
    read_byte(1'b0, v, w);
    chk("R7 stretched until tx valid", {31'h0, (w > 100)}, 1);
    chk("R7 late read byte", {24'h0, v}, 32'h4E);
    m_stop();
    tick(20);

    // R3: mismatching addresses are ignored
    quiet_req = "R3 bus untouched on mismatch";
    m_start();
    send_byte({7'h33, 1'b0}, a); chk("R3 no ack wrong write address", {31'h0, a}, 0);
    send_byte(8'h00, a); chk("R3 no ack for data", {31'h0, a}, 0);
    m_start();
    send_byte({7'h5B, 1'b1}, a); chk("R3 no ack near read address", {31'h0, a}, 0);
    clk_bit(1'b1, s); chk("R3 no read data", {31'h0, s}, 1);
    m_stop();
    tick(10);
    quiet_req = "";

    // R9: repeated start in mid-byte
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R9 first address ack", {31'h0, a}, 1);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s);
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R9 address ack after restart", {31'h0, a}, 1);
    rxq.push_back(8'h11);
    send_byte(8'h11, a); chk("R9 data ack after restart", {31'h0, a}, 1);
    m_stop();
    tick(40);
    chk("R9 only the full byte delivered", rxq.size(), 0);

    // R10: stop in mid-byte
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R10 address ack", {31'h0, a}, 1);
    clk_bit(1'b1, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    m_stop();
    quiet_req = "R10 idle after early stop";
    tick(100);
    quiet_req = "";
    chk("R10 no partial byte", {31'h0, rx_valid_o}, 0);
    m_start();
    send_byte({DEV, 1'b0}, a); chk("R10 address ack after idle", {31'h0, a}, 1);
    rxq.push_back(8'h77);
    send_byte(8'h77, a); chk("R10 data ack after idle", {31'h0, a}, 1);
    m_stop();
    tick(40);
    chk("R10 new frame delivered", rxq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  logic [7:0] v_list[4] = '{8'hA5, 8'h3C, 8'h00, 8'hFF};

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule